// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

A single 16-bit timer channel that builds two output waveforms from one counter. The counter advances on a count-enable strobe supplied by the surrounding clocking logic, following one of four counting profiles. On every counted step, the value held before the step is compared against three programmable values, A, B and C. Each match, an edge on the external event input, and a software trigger can each set, clear or toggle output A or output B. A separate action field is provided for every pairing of event and output.

Software programs the channel through a small word-addressed register interface. That interface carries a command register, a mode register, the three compare values, a readable counter, a status register that clears when read, and an interrupt mask with set and clear ports. A match on value C can freeze the counter or switch the channel clock off. A trigger, from software or from the external event, restarts the count from zero on the next counted step.

Top module: `wave_timer_chan`

Word addresses: 0 command, 1 mode, 2 compare A, 3 compare B, 4 compare C, 5 counter (read only), 6 status (read only), 7 mask set, 8 mask clear, 9 mask (read only). Mode fields: [1:0] profile, [2] stop on C, [3] clock off on C, [5:4] event edge, [6] event is trigger, [9:8] A on A-match, [11:10] A on C-match, [13:12] A on event, [15:14] A on software trigger, [17:16] B on B-match, [19:18] B on C-match, [21:20] B on event, [23:22] B on software trigger.

## Requirements
- R1: After reset the outputs are low, the counter is 0, the clock is off, and the status, mask and irq are all 0.
- R2: A write to the command register acts on three bits: bit 0 switches the clock on, bit 1 switches it off, and bit 2 issues a software trigger. When bits 0 and 1 are written together, the clock is switched off. The command register always reads as 0.
- R3: The counter moves by one step on each tick while the clock is on and the counter is not frozen. In all other cycles it holds its value.
- R4: Profile 0 counts up and wraps from 0xFFFF to 0. Profile 2 counts up and returns to 0 on the step taken from the C value.
- R5: Profiles 1 and 3 count up, then down. They turn downward on the step taken at 0xFFFF (profile 1) or at the C value (profile 3), and turn upward again on the step taken at 0.
- R6: Status bit 0 (overflow) is set when an up-counting profile wraps from 0xFFFF to 0.
- R7: A trigger comes from software, or from a detected external event when mode bit 6 is 1. On the next counted tick it forces the counter to 0 and the direction to up. It also unfreezes a frozen counter, and the clock stays on.
- R8: Each action field is coded 0 = no change, 1 = set, 2 = clear, 3 = toggle. A match means the counter equals A, B or C on a counted step.
- R9: When several events hit the same output in one cycle, the action applied is that of the highest-priority event whose action is not 0. The order is software trigger, then external event, then C-match, then A- or B-match.
- R10: When a C-match occurs with mode bit 2 set, the counter freezes at C and the clock stays on. When mode bit 3 is set, the counter holds C and the clock is switched off.
- R11: The event edge field is coded 0 = none, 1 = rising, 2 = falling, 3 = both. A detected edge sets status bit 7.
- R12: Status bits: 2, 3 and 4 are the A, B and C matches; 16 is clock on; 17 and 18 are the levels of outputs A and B. The flag bits [7:0] clear when status is read, unless an event sets them in the same cycle.
- R13: Writing 1s to the mask set or mask clear register sets or clears those bits of the mask. The irq output is high while any flag is set under a set mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when at address 6) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| tick | input | 1 | Count-enable strobe |
| ext_in | input | 1 | External event input, synchronous to clk |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
The case of interest is an external event that lands in the same cycle as a C-match, where both events carry actions for output A. The bench first drives A high. It then programs a C-match action of "set" and an event action of "clear", counts up to C, and raises the tick and a rising event edge in the same cycle. The result is judged by A going low, which is only correct if the event action took priority. The same cycle must still show both the C-match and the event flags in status. The following tick must leave the counter at 0, because the event also acted as a trigger.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    PROF_UP     = 2'd0,
    PROF_UPDN   = 2'd1,
    PROF_UPRC   = 2'd2,
    PROF_UPDNRC = 2'd3
  } prof_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_e;

  // mode register image, MSB first
  typedef struct packed {
    act_e  b_sw;
    act_e  b_evt;
    act_e  b_rc;
    act_e  b_cmp;
    act_e  a_sw;
    act_e  a_evt;
    act_e  a_rc;
    act_e  a_cmp;
    logic  rsvd;
    logic  evt_trig;
    edge_e evt_edge;
    logic  rc_dis;
    logic  rc_stop;
    prof_e prof;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
  localparam int NOUT   = 2;
  localparam int FLAG_W = 8;

  localparam int A_CTRL  = 0;
  localparam int A_MODE  = 1;
  localparam int A_CMPA  = 2;
  localparam int A_CMPB  = 3;
  localparam int A_CMPC  = 4;
  localparam int A_CNT   = 5;
  localparam int A_STAT  = 6;
  localparam int A_MSET  = 7;
  localparam int A_MCLR  = 8;
  localparam int A_MASK  = 9;

  localparam int ST_OVF  = 0;
  localparam int ST_CMPA = 2;
  localparam int ST_CMPB = 3;
  localparam int ST_CMPC = 4;
  localparam int ST_EXT  = 7;
  localparam int ST_CLK  = 16;
  localparam int ST_LVA  = 17;
  localparam int ST_LVB  = 18;

  function automatic logic act_apply(input logic cur, input act_e a);
    logic r;
    unique case (a)
      ACT_SET: r = 1'b1;
      ACT_CLR: r = 1'b0;
      ACT_TGL: r = ~cur;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wtc_regs.sv
module wtc_regs
  import wtc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output mode_t             mode,
  output logic [CW-1:0]     cmp_a,
  output logic [CW-1:0]     cmp_b,
  output logic [CW-1:0]     cmp_c,
  output logic              cmd_en,
  output logic              cmd_dis,
  output logic              cmd_sw,
  input  logic              ev_ovf,
  input  logic              ev_cmpa,
  input  logic              ev_cmpb,
  input  logic              ev_cmpc,
  input  logic              ev_ext,
  input  logic [CW-1:0]     cnt,
  input  logic              clk_on,
  input  logic              lvl_a,
  input  logic              lvl_b,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] mask,
  output logic              irq
);

  localparam logic [MODE_W-1:0] MODE_WMASK = ~(MODE_W'(1) << 7);

  mode_t             mode_q, mode_n;
  logic [CW-1:0]     a_q, a_n, b_q, b_n, c_q, c_n;
  logic [FLAG_W-1:0] flg_q, flg_n, msk_q, msk_n, ev_vec;
  logic              wr_ctrl, rd_stat;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[DW-1:MODE_W];

  assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
  assign rd_stat = rd_en && (addr == AW'(A_STAT));
  assign cmd_en  = wr_ctrl && wdata[0];
  assign cmd_dis = wr_ctrl && wdata[1];
  assign cmd_sw  = wr_ctrl && wdata[2];

  always_comb begin
    ev_vec          = '0;
    ev_vec[ST_OVF]  = ev_ovf;
    ev_vec[ST_CMPA] = ev_cmpa;
    ev_vec[ST_CMPB] = ev_cmpb;
    ev_vec[ST_CMPC] = ev_cmpc;
    ev_vec[ST_EXT]  = ev_ext;
  end

  always_comb begin
    mode_n = mode_q;
    a_n    = a_q;
    b_n    = b_q;
    c_n    = c_q;
    msk_n  = msk_q;
    if (wr_en) begin
      if (addr == AW'(A_MODE)) mode_n = mode_t'(wdata[MODE_W-1:0] & MODE_WMASK);
      if (addr == AW'(A_CMPA)) a_n = wdata[CW-1:0];
      if (addr == AW'(A_CMPB)) b_n = wdata[CW-1:0];
      if (addr == AW'(A_CMPC)) c_n = wdata[CW-1:0];
      if (addr == AW'(A_MSET)) msk_n = msk_q | wdata[FLAG_W-1:0];
      if (addr == AW'(A_MCLR)) msk_n = msk_q & ~wdata[FLAG_W-1:0];
    end
    flg_n = (rd_stat ? '0 : flg_q) | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      flg_q  <= '0;
      msk_q  <= '0;
    end else begin
      mode_q <= mode_n;
      a_q    <= a_n;
      b_q    <= b_n;
      c_q    <= c_n;
      flg_q  <= flg_n;
      msk_q  <= msk_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (int'(addr))
      A_MODE: rdata[MODE_W-1:0] = mode_q;
      A_CMPA: rdata[CW-1:0]     = a_q;
      A_CMPB: rdata[CW-1:0]     = b_q;
      A_CMPC: rdata[CW-1:0]     = c_q;
      A_CNT:  rdata[CW-1:0]     = cnt;
      A_STAT: begin
        rdata[FLAG_W-1:0] = flg_q;
        rdata[ST_CLK]     = clk_on;
        rdata[ST_LVA]     = lvl_a;
        rdata[ST_LVB]     = lvl_b;
      end
      A_MASK: rdata[FLAG_W-1:0] = msk_q;
      default: rdata = '0;
    endcase
  end

  assign mode  = mode_q;
  assign cmp_a = a_q;
  assign cmp_b = b_q;
  assign cmp_c = c_q;
  assign flags = flg_q;
  assign mask  = msk_q;
  assign irq   = |(flg_q & msk_q);

endmodule

// File: rtl/wtc_core.sv
module wtc_core
  import wtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ext_in,
  input  prof_e         prof,
  input  logic          rc_stop,
  input  logic          rc_dis,
  input  edge_e         evt_edge,
  input  logic          evt_trig,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [CW-1:0] cmp_c,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          cmd_sw,
  output logic [CW-1:0] cnt,
  output logic          clk_on,
  output logic          stopped,
  output logic          pending,
  output logic          halt,
  output logic          hit_a,
  output logic          hit_b,
  output logic          hit_c,
  output logic          ext_hit,
  output logic          ovf
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n, turn_at;
  logic          down_q, down_n, on_q, on_n, stop_q, stop_n, pend_q, pend_n;
  logic          ext_q, ext_rise, ext_fall, trig, step, cmp_ok;

  assign ext_rise = ext_in & ~ext_q;
  assign ext_fall = ~ext_in & ext_q;

  always_comb begin
    unique case (evt_edge)
      EDGE_RISE: ext_hit = ext_rise;
      EDGE_FALL: ext_hit = ext_fall;
      EDGE_ANY:  ext_hit = ext_rise | ext_fall;
      default:   ext_hit = 1'b0;
    endcase
  end

  assign trig    = cmd_sw | (ext_hit & evt_trig);
  assign step    = tick & on_q & (~stop_q | pend_q);
  assign cmp_ok  = step & ~pend_q;
  assign hit_a   = cmp_ok && (cnt_q == cmp_a);
  assign hit_b   = cmp_ok && (cnt_q == cmp_b);
  assign hit_c   = cmp_ok && (cnt_q == cmp_c);
  assign halt    = hit_c & (rc_stop | rc_dis);
  assign turn_at = (prof == PROF_UPDNRC) ? cmp_c : CNT_MAX;

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    stop_n = stop_q;
    pend_n = pend_q | trig;
    ovf    = 1'b0;
    if (step) begin
      if (pend_q) begin
        cnt_n  = '0;
        down_n = 1'b0;
        stop_n = 1'b0;
        pend_n = trig;
      end else if (halt) begin
        stop_n = stop_q | rc_stop;
      end else begin
        unique case (prof)
          PROF_UP: begin
            cnt_n = cnt_q + CNT_ONE;
            ovf   = (cnt_q == CNT_MAX);
          end
          PROF_UPRC: begin
            if (cnt_q == cmp_c) begin
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + CNT_ONE;
              ovf   = (cnt_q == CNT_MAX);
            end
          end
          default: begin
            if (!down_q) begin
              if (cnt_q == turn_at) begin
                down_n = 1'b1;
                cnt_n  = cnt_q - CNT_ONE;
              end else begin
                cnt_n  = cnt_q + CNT_ONE;
              end
            end else if (cnt_q == '0) begin
              down_n = 1'b0;
              cnt_n  = CNT_ONE;
            end else begin
              cnt_n  = cnt_q - CNT_ONE;
            end
          end
        endcase
      end
    end
    if (cmd_en) stop_n = 1'b0;
    if (cmd_dis)             on_n = 1'b0;
    else if (cmd_en)         on_n = 1'b1;
    else if (halt && rc_dis) on_n = 1'b0;
    else                     on_n = on_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      on_q   <= 1'b0;
      stop_q <= 1'b0;
      pend_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      on_q   <= on_n;
      stop_q <= stop_n;
      pend_q <= pend_n;
      ext_q  <= ext_in;
    end
  end

  assign cnt     = cnt_q;
  assign clk_on  = on_q;
  assign stopped = stop_q;
  assign pending = pend_q;

endmodule

// File: rtl/wtc_wave.sv
module wtc_wave
  import wtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  act_e            a_cmp,
  input  act_e            a_rc,
  input  act_e            a_evt,
  input  act_e            a_sw,
  input  act_e            b_cmp,
  input  act_e            b_rc,
  input  act_e            b_evt,
  input  act_e            b_sw,
  input  logic            hit_a,
  input  logic            hit_b,
  input  logic            hit_c,
  input  logic            ext_hit,
  input  logic            sw_hit,
  output logic [NOUT-1:0] lvl
);

  act_e            act_cmp [NOUT];
  act_e            act_rc  [NOUT];
  act_e            act_evt [NOUT];
  act_e            act_sw  [NOUT];
  logic [NOUT-1:0] hit_cmp;
  logic [NOUT-1:0] lvl_q, lvl_n;

  assign act_cmp[0] = a_cmp;
  assign act_cmp[1] = b_cmp;
  assign act_rc[0]  = a_rc;
  assign act_rc[1]  = b_rc;
  assign act_evt[0] = a_evt;
  assign act_evt[1] = b_evt;
  assign act_sw[0]  = a_sw;
  assign act_sw[1]  = b_sw;
  assign hit_cmp    = {hit_b, hit_a};

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    act_e sel;
    always_comb begin
      sel = ACT_NONE;
      if (hit_cmp[i] && act_cmp[i] != ACT_NONE) sel = act_cmp[i];
      if (hit_c      && act_rc[i]  != ACT_NONE) sel = act_rc[i];
      if (ext_hit    && act_evt[i] != ACT_NONE) sel = act_evt[i];
      if (sw_hit     && act_sw[i]  != ACT_NONE) sel = act_sw[i];
      lvl_n[i] = act_apply(lvl_q[i], sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_n;
  end

  assign lvl = lvl_q;

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tick,
  input  logic          ext_in,
  output logic          wave_a,
  output logic          wave_b,
  output logic          irq
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  mode_t             mode;
  logic [CW-1:0]     cmp_a, cmp_b, cmp_c, cnt;
  logic              cmd_en, cmd_dis, cmd_sw;
  logic              clk_on, stopped, pending, halt;
  logic              hit_a, hit_b, hit_c, ext_hit, ovf;
  logic [FLAG_W-1:0] flags, mask;
  logic [NOUT-1:0]   lvl;
  logic              unused_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n  = rst_pipe[1];
  assign unused_rsvd = mode.rsvd;

  wtc_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .mode(mode),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_sw(cmd_sw),
    .ev_ovf(ovf), .ev_cmpa(hit_a), .ev_cmpb(hit_b), .ev_cmpc(hit_c),
    .ev_ext(ext_hit), .cnt(cnt), .clk_on(clk_on),
    .lvl_a(lvl[0]), .lvl_b(lvl[1]), .flags(flags), .mask(mask), .irq(irq)
  );

  wtc_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .ext_in(ext_in),
    .prof(mode.prof), .rc_stop(mode.rc_stop), .rc_dis(mode.rc_dis),
    .evt_edge(mode.evt_edge), .evt_trig(mode.evt_trig),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_sw(cmd_sw),
    .cnt(cnt), .clk_on(clk_on), .stopped(stopped), .pending(pending),
    .halt(halt), .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c),
    .ext_hit(ext_hit), .ovf(ovf)
  );

  wtc_wave u_wave (
    .clk(clk), .rst_n(rst_sync_n),
    .a_cmp(mode.a_cmp), .a_rc(mode.a_rc), .a_evt(mode.a_evt), .a_sw(mode.a_sw),
    .b_cmp(mode.b_cmp), .b_rc(mode.b_rc), .b_evt(mode.b_evt), .b_sw(mode.b_sw),
    .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c), .ext_hit(ext_hit),
    .sw_hit(cmd_sw), .lvl(lvl)
  );

  assign wave_a = lvl[0];
  assign wave_b = lvl[1];

endmodule

// File: rtl/wtc_chk.sv
module wtc_chk
  import wtc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic              tick,
  input logic [CW-1:0]     cnt,
  input logic              clk_on,
  input logic              stopped,
  input logic              pending,
  input logic              halt,
  input prof_e             prof,
  input logic              hit_a,
  input logic              hit_c,
  input logic              ext_hit,
  input logic              cmd_sw,
  input logic [FLAG_W-1:0] flags,
  input logic              wave_a
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  assert_disable_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_CTRL) && wdata[1]) |=> !clk_on);

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_on && !stopped && !pending && !halt && prof == PROF_UP)
      |=> cnt == $past(cnt) + CW'(1));

  assert_ovf_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[ST_OVF]) |-> $past(cnt) == CNT_MAX);

  assert_wave_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_a) |-> $past(hit_a || hit_c || ext_hit || cmd_sw));

endmodule

bind wave_timer_chan wtc_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tick(tick), .cnt(cnt), .clk_on(clk_on), .stopped(stopped),
  .pending(pending), .halt(halt), .prof(mode.prof), .hit_a(hit_a),
  .hit_c(hit_c), .ext_hit(ext_hit), .cmd_sw(cmd_sw), .flags(flags),
  .wave_a(wave_a)
);

// File: tb/wave_timer_chan_tb_top.sv
`timescale 1ns/1ps
module wave_timer_chan_tb_top;

  localparam logic [3:0] OP_WR = 4'h0, OP_RD = 4'h1, OP_TK = 4'h2;
  localparam logic [3:0] CTRL = 4'd0, MODE = 4'd1, CA = 4'd2, CB = 4'd3, CC = 4'd4,
                         CNT = 4'd5, STAT = 4'd6, MSET = 4'd7, MCLR = 4'd8, MASK = 4'd9;
  localparam int NVEC = 11;
  // {op, addr, data}: data is write value, expected read value or tick count
  localparam logic [39:0] VEC [NVEC] = '{
    {OP_WR, CA,   32'd3},
    {OP_WR, CB,   32'd5},
    {OP_WR, CC,   32'd8},
    {OP_WR, MODE, 32'h0003_0902},
    {OP_WR, CTRL, 32'd1},
    {OP_TK, CNT,  32'd4},
    {OP_RD, CNT,  32'd4},
    {OP_RD, STAT, 32'h0003_0004},
    {OP_TK, CNT,  32'd5},
    {OP_RD, STAT, 32'h0005_0018},
    {OP_RD, CNT,  32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, ext_in = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wave_a, wave_b, irq;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  wave_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .ext_in(ext_in),
    .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] m,
                       input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 check(rdata & m, e, tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check({29'd0, wave_a, wave_b, irq}, 32'd0, "R1 outputs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_rd(STAT, 32'hFFFF_FFFF, 32'd0, "R1 status after reset");
    do_rd(CNT,  32'hFFFF_FFFF, 32'd0, "R1 counter after reset");
    do_rd(MASK, 32'hFFFF_FFFF, 32'd0, "R1 mask after reset");

    // R4 R8 R12: up with reset at C, A set on A-match, cleared on C, B toggles
    for (int i = 0; i < NVEC; i++) begin
      unique case (VEC[i][39:36])
        OP_WR: do_wr(VEC[i][35:32], VEC[i][31:0]);
        OP_TK: do_tick(int'(VEC[i][31:0]));
        default: do_rd(VEC[i][35:32], 32'hFFFF_FFFF, VEC[i][31:0],
                       $sformatf("R4/R8/R12 vector %0d", i));
      endcase
    end

    // R5: up/down turning at C=4; software trigger sets A
    do_wr(MODE, 32'h0000_4003);
    do_wr(CC, 32'd4);
    do_wr(CTRL, 32'd4);
    do_tick(1);
    do_tick(4);
    do_tick(2);
    do_rd(CNT, 32'hFFFF_FFFF, 32'd2, "R5 down after turn at C");
    do_tick(3);
    do_rd(CNT, 32'hFFFF_FFFF, 32'd1, "R5 up after turn at zero");
    #1 check({31'd0, wave_a}, 32'd1, "R8 software trigger set action");

    // R6: up-only wrap
    do_wr(MODE, 32'h0);
    do_wr(CTRL, 32'd4);
    do_tick(1);
    do_tick(65536);
    do_rd(CNT,  32'hFFFF_FFFF, 32'd0, "R4 up-only wraps to zero");
    do_rd(STAT, 32'h1, 32'h1, "R6 overflow flag");

    // R10: stop on C
    do_wr(MODE, 32'h4);
    do_wr(CC, 32'd3);
    do_wr(CTRL, 32'd4);
    do_tick(1);
    do_tick(5);
    do_rd(CNT,  32'hFFFF_FFFF, 32'd3, "R10 frozen at C");
    do_rd(STAT, 32'h1_0000, 32'h1_0000, "R10 clock stays on when frozen");
    do_wr(CTRL, 32'd4);
    do_tick(1);
    do_tick(2);
    do_rd(CNT, 32'hFFFF_FFFF, 32'd2, "R7 trigger restarts frozen counter");

    // R10: clock off on C
    do_wr(MODE, 32'h8);
    do_tick(3);
    do_rd(CNT,  32'hFFFF_FFFF, 32'd3, "R10 holds C on clock off");
    do_rd(STAT, 32'h1_0000, 32'h0, "R10 clock switched off");
    do_tick(2);
    do_rd(CNT, 32'hFFFF_FFFF, 32'd3, "R3 no count with clock off");
    do_wr(CTRL, 32'd5);
    do_tick(1);
    do_rd(CNT,  32'hFFFF_FFFF, 32'd0, "R7 trigger resets counter");
    do_rd(STAT, 32'h1_0000, 32'h1_0000, "R2 enable command");

    // R2: enable and disable together
    do_wr(CTRL, 32'd3);
    do_rd(STAT, 32'h1_0000, 32'h0, "R2 disable wins");
    do_tick(2);
    do_rd(CNT, 32'hFFFF_FFFF, 32'd0, "R3 hold while off");

    // R9 R11 R13: event clear versus C-match set on A, same cycle
    do_wr(MSET, 32'h10);
    do_rd(MASK, 32'hFFFF_FFFF, 32'h10, "R13 mask set");
    do_wr(CC, 32'd6);
    do_wr(MODE, 32'h0000_2452);
    do_wr(CTRL, 32'd5);
    do_tick(1);
    do_tick(6);
    do_rd(STAT, 32'h0, 32'h0, "R12 clearing read");
    #1 check({31'd0, wave_a}, 32'd1, "R9 A high before collision");
    @(negedge clk); tick = 1'b1; ext_in = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 check({31'd0, wave_a}, 32'd0, "R9 event action beats C-match");
    check({31'd0, irq}, 32'd1, "R13 irq on masked C flag");
    do_rd(STAT, 32'h90, 32'h90, "R11 event and C flags together");
    #1 check({31'd0, irq}, 32'd0, "R13 irq low after status read");
    do_tick(1);
    do_rd(CNT, 32'hFFFF_FFFF, 32'd0, "R7 event trigger resets counter");
    @(negedge clk); ext_in = 1'b0;
    @(negedge clk);
    do_rd(STAT, 32'h80, 32'h0, "R11 falling edge ignored on rising select");
    do_wr(MCLR, 32'h10);
    do_rd(MASK, 32'hFFFF_FFFF, 32'h0, "R13 mask clear");
    do_rd(CTRL, 32'hFFFF_FFFF, 32'h0, "R2 command reads zero");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule